// File: doc/BRIEF.md
# Serial Command Register Port

This block is a serial-bus slave (clock idle low, data captured on the rising clock edge, changed on the falling edge). Each chip-select frame carries one 16-bit command. When the frame closes, a small controller decodes the command. It then reads or writes one of a handful of registers through two logical ports. The three serial pins are brought into the system clock domain through synchronisers. All internal logic runs on that clock.

Port 0 always reaches the main control register. That register drives four indicator lines and a converter-enable line. It also holds a two-bit field that routes port 1 to one of four targets:

- a first auxiliary register,
- a second auxiliary register,
- a pattern counter,
- the read side of a sample queue.

The queue is outside the block. The block sees only its head word and an empty flag, and it drives a one-cycle pop strobe.

The answer to a command is never returned in the same frame. It is placed in a reply register and shifted out on the data-out line, most significant bit first, during the next frame. A host therefore always reads the result of its previous command. To stream from the queue, the host selects it once and then issues a run of port 1 read commands.

Top module: `spi_port_ctrl`

## Requirements
- R1: A command word holds the opcode in bits 3:0 and a 12-bit payload in bits 15:4. Opcode bit 0 set means write and clear means read. Opcode bit 1 set means port 1 and clear means port 0. Opcode bits 3:2 have no effect.
- R2: A port 0 command always accesses the main control register, whatever the routing field holds.
- R3: In the main control register, bits 3:0 drive `ledOut[3:0]`, bit 4 drives `adcEnOut`, and bits 6:5 are the port 1 routing field. Bits 11:7 are stored and read back unchanged.
- R4: The port 1 routing field selects the target: 00 selects auxiliary register A, 01 selects auxiliary register B, 10 selects the pattern counter, and 11 selects the sample queue.
- R5: A write to a register or to the counter stores the 12-bit payload. The next reply is the previous contents, zero-extended to 16 bits.
- R6: A read leaves its target unchanged and ignores the payload. The next reply is the current contents, zero-extended to 16 bits.
- R7: The reply to a command is shifted out MSB first during the following frame. MOSI is sampled on rising SCLK edges, MSB first.
- R8: A read of the pattern counter returns its value and then advances it by one, wrapping at 12 bits. A write loads it.
- R9: A port 1 read with the queue selected and the queue not empty replies with the head word in bits 11:0, bits 15:12 clear, and pops exactly one word.
- R10: A port 1 read with the queue selected and the queue empty replies 0x8000 (bit 15 flags empty) and does not pop.
- R11: A port 1 write with the queue selected has no effect on any register. It replies 0x0000 and does not pop.
- R12: A command executes only when chip-select rises after exactly 16 rising SCLK edges. Any other frame changes no register and no output, and the pending reply stays as it was.
- R13: After reset, all registers, the counter and the pending reply are zero, and no pop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the host (asynchronous) |
| csnIn | input | 1 | Active-low frame select from the host |
| mosiIn | input | 1 | Serial command data from the host |
| fifoData | input | 12 | Head word of the sample queue |
| fifoEmpty | input | 1 | Sample queue holds no word |
| misoOut | output | 1 | Serial reply data to the host |
| ledOut | output | 4 | Indicator drive from the main control register |
| adcEnOut | output | 1 | Converter sampling enable |
| fifoPop | output | 1 | One-cycle strobe that removes the queue head |

## Verification
The bench targets the following corner cases, and each has a visible symptom if the design gets it wrong:

- **Short and long frames.** The bench sends frames of 0, 15 and 17 clocks. A design that executed them would corrupt a register or overwrite the pending reply.
- **Empty queue reads.** A design that popped on an empty read would leave the pop count ahead of the model.
- **Late replies.** Every reply is compared with the model's answer to the previous command, so an off-by-one-frame reply or a bit-order slip shows at once.
- **Reserved opcode bits, payloads on reads, and routing changes in mid-stream.** Random commands mix all three. A design that decoded the reserved bits or let a read store its payload would drift from the model in later replies.
- **Counter wrap.** A directed load near 0xFFF followed by reads catches a counter that does not wrap at 12 bits.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int WORD_W   = 16;
  localparam int OP_W     = 4;
  localparam int DATA_W   = WORD_W - OP_W;
  localparam int LED_W    = 4;
  localparam int ADC_BIT  = 4;
  localparam int SEL_LSB  = 5;
  localparam int EMPTY_BIT = WORD_W - 1;

  typedef struct packed {
    logic loadTx;    // frame opened: copy pending reply into the shifter
    logic shiftTx;   // falling SCLK: present next reply bit
    logic sampleRx;  // rising SCLK: capture one command bit
    logic exec;      // valid frame closed: run the command
  } spcStrobe_t;

  typedef enum logic [1:0] {
    SEL_AUXA = 2'b00,
    SEL_AUXB = 2'b01,
    SEL_CNT  = 2'b10,
    SEL_FIFO = 2'b11
  } spcSel_e;
endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csnIn,
  input  logic mosiIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csnRise,
  output logic csnFall,
  output logic mosiSync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sclkPipe, csnPipe, mosiPipe;
  logic sclkLast, csnLast;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csnPipe  <= '1;
          mosiPipe <= '0;
        end else begin
          sclkPipe <= sclkIn;
          csnPipe  <= csnIn;
          mosiPipe <= mosiIn;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csnPipe  <= '1;
          mosiPipe <= '0;
        end else begin
          sclkPipe <= {sclkPipe[LAST-1:0], sclkIn};
          csnPipe  <= {csnPipe[LAST-1:0], csnIn};
          mosiPipe <= {mosiPipe[LAST-1:0], mosiIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkLast <= 1'b0;
      csnLast  <= 1'b1;
    end else begin
      sclkLast <= sclkPipe[LAST];
      csnLast  <= csnPipe[LAST];
    end
  end

  assign sclkRise = sclkPipe[LAST] & ~sclkLast;
  assign sclkFall = ~sclkPipe[LAST] & sclkLast;
  assign csnRise  = csnPipe[LAST] & ~csnLast;
  assign csnFall  = ~csnPipe[LAST] & csnLast;
  assign mosiSync = mosiPipe[LAST];
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       csnRise,
  input  logic       csnFall,
  output spcStrobe_t strb
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  typedef enum logic {ST_IDLE, ST_FRAME} ctrlState_e;

  ctrlState_e state;
  logic [CNT_W-1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (csnFall) begin
          state   <= ST_FRAME;
          edgeCnt <= '0;
        end
        ST_FRAME: begin
          if (csnRise) state <= ST_IDLE;
          else if (sclkRise && edgeCnt != OVER) edgeCnt <= edgeCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadTx   = (state == ST_IDLE) && csnFall;
    strb.sampleRx = (state == ST_FRAME) && sclkRise && !csnRise;
    strb.shiftTx  = (state == ST_FRAME) && sclkFall && !csnRise;
    strb.exec     = (state == ST_FRAME) && csnRise && (edgeCnt == FULL);
  end
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spcStrobe_t        strb,
  input  logic              mosiSync,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              misoOut,
  output logic [LED_W-1:0]  ledOut,
  output logic              adcEnOut,
  output logic              fifoPop
);
  localparam int PAD_W = WORD_W - DATA_W;
  localparam logic [WORD_W-1:0] EMPTY_REPLY = WORD_W'(1) << EMPTY_BIT;

  logic [WORD_W-1:0] rxShift, txShift, reply;
  logic [DATA_W-1:0] ctlMain, auxA, auxB, patCnt;

  logic [OP_W-1:0]   opcode;
  logic [DATA_W-1:0] payload;
  logic              isWrite, toPort1;
  spcSel_e           route;
  logic [DATA_W-1:0] curVal;
  logic [WORD_W-1:0] replyNext;
  logic              popNext;

  assign opcode  = rxShift[OP_W-1:0];
  assign payload = rxShift[WORD_W-1:OP_W];
  assign isWrite = opcode[0];
  assign toPort1 = opcode[1];
  assign route   = spcSel_e'(ctlMain[SEL_LSB+1:SEL_LSB]);

  always_comb begin
    curVal    = ctlMain;
    replyNext = '0;
    popNext   = 1'b0;
    if (toPort1) begin
      case (route)
        SEL_AUXA: curVal = auxA;
        SEL_AUXB: curVal = auxB;
        SEL_CNT:  curVal = patCnt;
        default:  curVal = fifoData;
      endcase
    end
    if (toPort1 && route == SEL_FIFO) begin
      if (isWrite)        replyNext = '0;
      else if (fifoEmpty) replyNext = EMPTY_REPLY;
      else begin
        replyNext = {{PAD_W{1'b0}}, fifoData};
        popNext   = 1'b1;
      end
    end else begin
      replyNext = {{PAD_W{1'b0}}, curVal};
    end
  end

  // serial shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (strb.sampleRx) rxShift <= {rxShift[WORD_W-2:0], mosiSync};
      if (strb.loadTx)       txShift <= reply;
      else if (strb.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  // command execution
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reply   <= '0;
      ctlMain <= '0;
      auxA    <= '0;
      auxB    <= '0;
      patCnt  <= '0;
      fifoPop <= 1'b0;
    end else begin
      fifoPop <= 1'b0;
      if (strb.exec) begin
        reply   <= replyNext;
        fifoPop <= popNext;
        if (!toPort1) begin
          if (isWrite) ctlMain <= payload;
        end else begin
          case (route)
            SEL_AUXA: if (isWrite) auxA <= payload;
            SEL_AUXB: if (isWrite) auxB <= payload;
            SEL_CNT:  patCnt <= isWrite ? payload : patCnt + DATA_W'(1);
            default:  ;
          endcase
        end
      end
    end
  end

  assign misoOut  = txShift[WORD_W-1];
  assign ledOut   = ctlMain[LED_W-1:0];
  assign adcEnOut = ctlMain[ADC_BIT];
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csnIn,
  input  logic              mosiIn,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              misoOut,
  output logic [LED_W-1:0]  ledOut,
  output logic              adcEnOut,
  output logic              fifoPop
);
  logic sclkRise, sclkFall, csnRise, csnFall, mosiSync;
  spcStrobe_t strb;

  spc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn), .mosiIn(mosiIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csnRise(csnRise),
    .csnFall(csnFall), .mosiSync(mosiSync)
  );

  spc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csnRise(csnRise), .csnFall(csnFall), .strb(strb)
  );

  spc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiSync(mosiSync),
    .fifoData(fifoData), .fifoEmpty(fifoEmpty), .misoOut(misoOut),
    .ledOut(ledOut), .adcEnOut(adcEnOut), .fifoPop(fifoPop)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input spcStrobe_t       strb,
  input logic             fifoEmpty,
  input logic             fifoPop,
  input logic [LED_W-1:0] ledOut,
  input logic             adcEnOut,
  input logic             misoOut
);
  a_r10_empty_no_pop: assert property (@(posedge clk) disable iff (!rstN)
    (strb.exec && fifoEmpty) |=> !fifoPop);

  a_r9_single_pop: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  a_r12_pop_after_exec: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> $past(strb.exec));

  a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.exec |=> ($stable(ledOut) && $stable(adcEnOut)));

  a_r7_miso_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadTx || strb.shiftTx) |=> $stable(misoOut));
endmodule

bind spi_port_ctrl spc_checker u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .fifoEmpty(fifoEmpty),
  .fifoPop(fifoPop), .ledOut(ledOut), .adcEnOut(adcEnOut), .misoOut(misoOut)
);

// File: tb/spi_port_ctrl_test.sv
module spi_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b0, csnIn = 1'b1, mosiIn = 1'b0;
  logic [11:0] fifoData;
  logic        fifoEmpty;
  logic        misoOut, adcEnOut, fifoPop;
  logic [3:0]  ledOut;

  int checks = 0, fails = 0;
  bit done = 0;

  // sample queue model
  logic [11:0] qMem [0:15];
  int qCount = 0, qHead = 0, popSeen = 0;
  int mHead = 0, expPops = 0;

  // register model
  logic [11:0] mMain = 0, mAuxA = 0, mAuxB = 0, mCnt = 0;
  logic [15:0] mReply = 0;

  always #10 clk = ~clk;

  assign fifoEmpty = (qHead >= qCount);
  assign fifoData  = qMem[qHead[3:0]];

  always @(posedge clk) if (fifoPop) begin
    qHead   <= qHead + 1;
    popSeen <= popSeen + 1;
  end

  spi_port_ctrl uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn), .mosiIn(mosiIn),
    .fifoData(fifoData), .fifoEmpty(fifoEmpty), .misoOut(misoOut),
    .ledOut(ledOut), .adcEnOut(adcEnOut), .fifoPop(fifoPop)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame with nEdges rising SCLK edges; returns bits seen on MISO
  task automatic xfer(input logic [15:0] cmd, input int nEdges, output logic [15:0] got);
    got = '0;
    csnIn = 1'b0;
    waitClk(6);
    for (int i = 0; i < nEdges; i++) begin
      mosiIn = (i < 16) ? cmd[15-i] : 1'b0;
      waitClk(4);
      if (i < 16) got[15-i] = misoOut;
      sclkIn = 1'b1;
      waitClk(4);
      sclkIn = 1'b0;
    end
    waitClk(4);
    csnIn = 1'b1;
    waitClk(8);
  endtask

  function automatic logic [15:0] mkCmd(input logic [11:0] d, input logic [3:0] op);
    return {d, op};
  endfunction

  task automatic modelExec(input logic [15:0] cmd);
    logic [11:0] d = cmd[15:4];
    logic w = cmd[0];
    logic p1 = cmd[1];
    if (!p1) begin
      mReply = {4'h0, mMain};
      if (w) mMain = d;
    end else begin
      case (mMain[6:5])
        2'b00: begin mReply = {4'h0, mAuxA}; if (w) mAuxA = d; end
        2'b01: begin mReply = {4'h0, mAuxB}; if (w) mAuxB = d; end
        2'b10: begin mReply = {4'h0, mCnt}; mCnt = w ? d : mCnt + 12'd1; end
        default: begin
          if (w) mReply = 16'h0000;
          else if (mHead >= qCount) mReply = 16'h8000;
          else begin
            mReply = {4'h0, qMem[mHead[3:0]]};
            mHead++;
            expPops++;
          end
        end
      endcase
    end
  endtask

  // run one frame, compare reply with the model's previous answer, then update the model
  task automatic step(input logic [15:0] cmd, input int nEdges, input string req);
    logic [15:0] got;
    logic [15:0] prev = mReply;
    xfer(cmd, nEdges, got);
    if (nEdges == 16) begin
      check(req, got, prev);
      modelExec(cmd);
    end
    check("R3", {27'd0, adcEnOut, ledOut}, {27'd0, mMain[4], mMain[3:0]});
  endtask

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd20240517);
    for (int i = 0; i < 16; i++) qMem[i] = 12'h100 + 12'(i * 37);
    qCount = 4;
    waitClk(3);
    check("R13", {30'd0, ledOut != 0, adcEnOut}, 32'd0);
    rstN = 1'b1;
    waitClk(3);
    check("R13", {31'd0, misoOut}, 32'd0);
    check("R13", {31'd0, fifoPop}, 32'd0);

    // first reply after reset is zero
    step(mkCmd(12'h000, 4'b0000), 16, "R13");
    // main register write: leds=0xA, adc on, route aux A
    step(mkCmd(12'h01A, 4'b0001), 16, "R5");
    step(mkCmd(12'hFFF, 4'b0000), 16, "R5");          // read returns 0x01A, payload ignored
    step(mkCmd(12'h123, 4'b0011), 16, "R6");          // aux A write
    step(mkCmd(12'h03A, 4'b1101), 16, "R1");          // reserved bits set, port 0 write: route B
    step(mkCmd(12'h456, 4'b1111), 16, "R4");          // aux B write via reserved-bit opcode
    step(mkCmd(12'h05A, 4'b0001), 16, "R4");          // route counter
    step(mkCmd(12'hFFE, 4'b0011), 16, "R8");          // counter load near wrap
    for (int i = 0; i < 4; i++) step(mkCmd(12'h000, 4'b0010), 16, "R8");
    step(mkCmd(12'h07A, 4'b0101), 16, "R2");          // port 0 still main while routed
    for (int i = 0; i < 6; i++) step(mkCmd(12'hABC, 4'b0010), 16, "R9");
    step(mkCmd(12'h777, 4'b0011), 16, "R11");         // write to queue
    step(mkCmd(12'h000, 4'b0010), 16, "R10");
    // discarded frames
    step(mkCmd(12'h000, 4'b0001), 15, "R12");
    step(mkCmd(12'h000, 4'b0001), 17, "R12");
    step(mkCmd(12'h000, 4'b0001), 0, "R12");
    step(mkCmd(12'h000, 4'b0000), 16, "R12");
    check("R9", popSeen, expPops);

    qCount = 16;
    for (int n = 0; n < 300; n++) begin
      logic [15:0] c = 16'($urandom());
      int pick = int'($urandom_range(0, 19));
      int e = (pick == 0) ? 15 : (pick == 1) ? 17 : (pick == 2) ? 0 : 16;
      step(c, e, (e == 16) ? "R7" : "R12");
    end
    check("R10", popSeen, expPops);
    step(mkCmd(12'h000, 4'b0000), 16, "R7");
    check("R6", {20'd0, mMain}, {20'd0, mReply[11:0]});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule